// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is the sequencing engine of one DMA channel. Software loads a 16-bit start address, a 16-bit byte count and a small control byte through an 8-bit register port. The engine then waits for a device request, asks for the system bus and, once the bus is granted, runs bus cycles. In each cycle it drives the address, a read/write level and a valid-memory-access strobe. After each cycle it steps the address up or down and lowers the count by one. The engine never carries data. It only produces addresses and control, and it strobes and acknowledges the device in step with each bus cycle.

Three operating modes exist. In single-request-held mode the channel keeps the bus across the whole transfer and runs one byte per device request. In single-request-released mode it requests and releases the bus around every byte, again one byte per request. In block-released mode one device request starts a run to the end of the count, and the bus is released for at least one cycle between bytes. When the count reaches zero, the channel sets a sticky end flag, gives the device a one-cycle end pulse, drops its bus request and goes idle. Reading the control register clears the end flag.

Top module: `dmaseq_chan`

## Requirements
- R1: A synchronous active-low reset clears the address, count, control bits and end flag, and leaves the bus request, the valid strobe and busy low. All registers then read as 0.
- R2: A host write (cs=1, rw=0) is sampled on the falling clock edge and takes effect at the following rising edge. The register selects are: 0 address high byte, 1 address low byte, 2 count high byte, 3 count low byte, 4 control. Only control bits 3:0 are stored; bits 7:4 of written data are dropped. Writes to address or count are ignored while busy.
- R3: Control bit 0 sets the direction. bus_rw equals that bit during every valid bus cycle (1 = memory read, 0 = memory write).
- R4: Control bits 2:1 give the mode: 00 single/released, 01 block/released, 10 single/held. Code 11 starts nothing, and a count of zero starts nothing.
- R5: During a bus cycle bus_addr shows the current address. After each cycle the address steps by +1 when control bit 3 is 0 and by -1 when it is 1, wrapping modulo 2^16.
- R6: A bus cycle (bus_vma high) happens only while bus_gnt and bus_req are both high. Each such cycle lowers the count by exactly one. With no grant the count holds.
- R7: After the cycle that brings the count to zero, dev_end pulses for one cycle. The end flag is then set, and bus_req and busy are low.
- R8: The end flag (control bit 7) stays set until a host read of the control register clears it. If the set and the clear fall at the same rising edge, the set wins.
- R9: In the held mode bus_req stays high from the first bus cycle until the end pulse.
- R10: In the released modes bus_req is low in the cycle after every bus cycle.
- R11: Single modes run one bus cycle per device request. Block mode runs the whole count after one request. A request seen in an acknowledge cycle is ignored.
- R12: dev_stb is high in each bus cycle, and dev_ack pulses for one cycle in the cycle after it.
- R13: busy (also control bit 6, read-only) is high whenever the engine is requesting or holding the bus, or is between bytes of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Host register select strobe |
| rw | input | 1 | Host access direction, 1 read, 0 write |
| reg_sel | input | 3 | Host register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for reg_sel |
| dev_req | input | 1 | Device transfer request |
| dev_stb | output | 1 | Device strobe during a bus cycle |
| dev_ack | output | 1 | Device acknowledge, cycle after a bus cycle |
| dev_end | output | 1 | One-cycle end-of-transfer pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_vma | output | 1 | Valid memory access strobe |
| bus_rw | output | 1 | Bus cycle direction, 1 read |
| bus_addr | output | 16 | Bus address |
| busy | output | 1 | Channel busy |
| end_flag | output | 1 | Sticky end-of-transfer flag |

## Verification
Two events can land on the same rising edge: the end flag being set by the final bus cycle, and a host read of the control register trying to clear it. The bench forces the grant high so the final cycle's timing is known exactly. It places a control read so that its falling-edge sample lands inside the last bus cycle, then confirms that bus_vma is high in that cycle. It requires the flag to read as set afterwards, and clear only after a second, separate read.

// File: rtl/dmaseq_pkg.sv
// Shared definitions for the DMA channel sequencer.
// Assumes an 8-bit host port; register select and control bit positions are fixed here.
package dmaseq_pkg;

    // Host register selects
    localparam int OFS_AHI  = 0;
    localparam int OFS_ALO  = 1;
    localparam int OFS_CHI  = 2;
    localparam int OFS_CLO  = 3;
    localparam int OFS_CTRL = 4;

    // Control byte bit positions
    localparam int CB_DIR   = 0;
    localparam int CB_BLOCK = 1;
    localparam int CB_STYLE = 2;
    localparam int CB_DEC   = 3;
    localparam int CB_BUSY  = 6;
    localparam int CB_END   = 7;
    localparam int CB_KEEP  = 4;   // number of stored low control bits

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    // Block with held request is the one undefined code
    function automatic logic mode_legal(input logic blk, input logic sty);
        return !(blk && sty);
    endfunction

endpackage

// File: rtl/dmaseq_hostif.sv
// Host access capture stage.
// Samples the host strobes on the falling clock edge so the rising-edge register
// file sees a stable, one-cycle-old write or read request.
// Assumes the host holds cs/rw/reg_sel/wdata across the falling edge.
module dmaseq_hostif #(
    parameter int DW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rw,
    input  logic [SW-1:0] reg_sel,
    input  logic [DW-1:0] wdata,
    output logic          wr_pend,
    output logic          rd_pend,
    output logic [SW-1:0] pend_sel,
    output logic [DW-1:0] pend_data
);

    // Falling-edge capture of the host access
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            wr_pend   <= 1'b0;
            rd_pend   <= 1'b0;
            pend_sel  <= '0;
            pend_data <= '0;
        end else begin
            wr_pend   <= cs && !rw;
            rd_pend   <= cs && rw;
            pend_sel  <= reg_sel;
            pend_data <= wdata;
        end
    end

endmodule

// File: rtl/dmaseq_regs.sv
// Channel register file: address, count, control bits and the sticky end flag.
// The engine's step has priority; host writes to address/count are dropped while busy.
// Assumes AW and CW exceed DW and fit in two host bytes.
module dmaseq_regs
    import dmaseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_pend,
    input  logic          rd_pend,
    input  logic [SW-1:0] pend_sel,
    input  logic [DW-1:0] pend_data,
    input  logic [SW-1:0] reg_sel,
    input  logic          busy,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          cnt_zero,
    output logic          cnt_last,
    output logic          c_dir,
    output logic          c_blk,
    output logic          c_sty,
    output logic          c_dec,
    output logic          end_flag,
    output logic [DW-1:0] rdata
);

    localparam int AHW = AW - DW;
    localparam int CHW = CW - DW;

    logic [AW-1:0]      addr_q;
    logic [CW-1:0]      cnt_q;
    logic [CB_KEEP-1:0] ctrl_q;
    logic               end_q;
    logic               host_ld;

    assign host_ld = wr_pend && !busy;

    // Address: step after each bus cycle, else byte loads from the host
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (step)
            addr_q <= ctrl_q[CB_DEC] ? addr_q - 1'b1 : addr_q + 1'b1;
        else if (host_ld && pend_sel == SW'(OFS_AHI))
            addr_q[AW-1:DW] <= pend_data[AHW-1:0];
        else if (host_ld && pend_sel == SW'(OFS_ALO))
            addr_q[DW-1:0] <= pend_data;
    end

    // Count: decrement per bus cycle, else byte loads from the host
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q - 1'b1;
        else if (host_ld && pend_sel == SW'(OFS_CHI))
            cnt_q[CW-1:DW] <= pend_data[CHW-1:0];
        else if (host_ld && pend_sel == SW'(OFS_CLO))
            cnt_q[DW-1:0] <= pend_data;
    end

    // Control bits: writable at any time, upper written bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_pend && pend_sel == SW'(OFS_CTRL))
            ctrl_q <= pend_data[CB_KEEP-1:0];
    end

    // End flag: set by final bus cycle, cleared by a control read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            end_q <= 1'b0;
        else if (step && cnt_last)
            end_q <= 1'b1;
        else if (rd_pend && pend_sel == SW'(OFS_CTRL))
            end_q <= 1'b0;
    end

    assign addr     = addr_q;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CW'(1));
    assign c_dir    = ctrl_q[CB_DIR];
    assign c_blk    = ctrl_q[CB_BLOCK];
    assign c_sty    = ctrl_q[CB_STYLE];
    assign c_dec    = ctrl_q[CB_DEC];
    assign end_flag = end_q;

    // Read mux on the live register select
    always_comb begin
        rdata = '0;
        if (reg_sel == SW'(OFS_AHI))
            rdata[AHW-1:0] = addr_q[AW-1:DW];
        else if (reg_sel == SW'(OFS_ALO))
            rdata = addr_q[DW-1:0];
        else if (reg_sel == SW'(OFS_CHI))
            rdata[CHW-1:0] = cnt_q[CW-1:DW];
        else if (reg_sel == SW'(OFS_CLO))
            rdata = cnt_q[DW-1:0];
        else if (reg_sel == SW'(OFS_CTRL)) begin
            rdata[CB_KEEP-1:0] = ctrl_q;
            rdata[CB_BUSY]     = busy;
            rdata[CB_END]      = end_q;
        end
    end

endmodule

// File: rtl/dmaseq_fsm.sv
// Transfer sequencer state machine.
// Decides when to request the bus, when a bus cycle happens and where to go
// after it, from the mode bits and the count status.
// Assumes bus_gnt may drop at any time; a bus cycle counts only with grant present.
module dmaseq_fsm
    import dmaseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_req,
    input  logic bus_gnt,
    input  logic c_dir,
    input  logic c_blk,
    input  logic c_sty,
    input  logic cnt_zero,
    input  logic cnt_last,
    output logic bus_req,
    output logic bus_vma,
    output logic bus_rw,
    output logic dev_stb,
    output logic dev_ack,
    output logic dev_end,
    output logic busy,
    output logic step
);

    seq_state_e st, nxt;
    logic       ack_q;
    logic       end_q;
    logic       req_ok;

    // A request in the acknowledge cycle is treated as the old one
    assign req_ok = dev_req && !ack_q;

    // Next-state selection
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE: if (req_ok && !cnt_zero && mode_legal(c_blk, c_sty)) nxt = ST_REQ;
            ST_REQ:  if (bus_gnt) nxt = ST_XFER;
            ST_XFER: begin
                if (!bus_gnt)      nxt = ST_REQ;
                else if (cnt_last) nxt = ST_IDLE;
                else if (c_sty)    nxt = ST_HOLD;
                else if (c_blk)    nxt = ST_GAP;
                else               nxt = ST_IDLE;
            end
            ST_HOLD: if (req_ok) nxt = ST_XFER;
            ST_GAP:  nxt = ST_REQ;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Registered acknowledge and end pulses, one cycle after the bus cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            end_q <= 1'b0;
        end else begin
            ack_q <= step;
            end_q <= step && cnt_last;
        end
    end

    assign step    = (st == ST_XFER) && bus_gnt;
    assign bus_vma = step;
    assign dev_stb = step;
    assign bus_rw  = step ? c_dir : 1'b1;
    assign bus_req = (st == ST_REQ) || (st == ST_XFER) || (st == ST_HOLD);
    assign busy    = (st != ST_IDLE);
    assign dev_ack = ack_q;
    assign dev_end = end_q;

endmodule

// File: rtl/dmaseq_chan.sv
// Single DMA channel sequencer top.
// Joins the falling-edge host capture, the register file and the sequencer.
// Assumes one bus master interface and one device; moves no data itself.
module dmaseq_chan #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rw,
    input  logic [SW-1:0] reg_sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          dev_req,
    output logic          dev_stb,
    output logic          dev_ack,
    output logic          dev_end,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_vma,
    output logic          bus_rw,
    output logic [AW-1:0] bus_addr,
    output logic          busy,
    output logic          end_flag
);

    logic          wr_pend, rd_pend;
    logic [SW-1:0] pend_sel;
    logic [DW-1:0] pend_data;
    logic          step, cnt_zero, cnt_last;
    logic          c_dir, c_blk, c_sty, c_dec;

    dmaseq_hostif #(.DW(DW), .SW(SW)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .rw        (rw),
        .reg_sel   (reg_sel),
        .wdata     (wdata),
        .wr_pend   (wr_pend),
        .rd_pend   (rd_pend),
        .pend_sel  (pend_sel),
        .pend_data (pend_data)
    );

    dmaseq_regs #(.AW(AW), .CW(CW), .DW(DW), .SW(SW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pend   (wr_pend),
        .rd_pend   (rd_pend),
        .pend_sel  (pend_sel),
        .pend_data (pend_data),
        .reg_sel   (reg_sel),
        .busy      (busy),
        .step      (step),
        .addr      (bus_addr),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .c_dir     (c_dir),
        .c_blk     (c_blk),
        .c_sty     (c_sty),
        .c_dec     (c_dec),
        .end_flag  (end_flag),
        .rdata     (rdata)
    );

    dmaseq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_req  (dev_req),
        .bus_gnt  (bus_gnt),
        .c_dir    (c_dir),
        .c_blk    (c_blk),
        .c_sty    (c_sty),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .bus_req  (bus_req),
        .bus_vma  (bus_vma),
        .bus_rw   (bus_rw),
        .dev_stb  (dev_stb),
        .dev_ack  (dev_ack),
        .dev_end  (dev_end),
        .busy     (busy),
        .step     (step)
    );

endmodule

// File: rtl/dmaseq_chan_chk.sv
// Property checker for the DMA channel sequencer, bound into every instance.
// Observes ports plus the stored mode bits and the captured host read.
module dmaseq_chan_chk
    import dmaseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          bus_vma,
    input logic [AW-1:0] bus_addr,
    input logic          dev_ack,
    input logic          dev_end,
    input logic          busy,
    input logic          end_flag,
    input logic          c_blk,
    input logic          c_sty,
    input logic          c_dec,
    input logic          rd_pend,
    input logic [SW-1:0] pend_sel
);

    // R12: acknowledge follows every bus cycle
    a_r12_ack_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vma |=> dev_ack);

    // R6: a bus cycle needs both request and grant
    a_r6_vma_granted: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vma |-> (bus_gnt && bus_req));

    // R7: end pulse coincides with idle channel and set flag
    a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dev_end |-> (!bus_req && !busy && end_flag));

    // R10: released modes drop the request after each bus cycle
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vma && !c_sty) |=> !bus_req);

    // R9: held mode keeps the request unless the transfer ended
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vma && c_sty) |=> (bus_req || dev_end));

    // R4: the undefined mode code never leaves idle
    a_r4_undef_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && c_blk && c_sty) |=> !busy);

    // R5: address has stepped by one in the acknowledge cycle
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> (bus_addr == ($past(c_dec) ? $past(bus_addr) - 1'b1
                                               : $past(bus_addr) + 1'b1)));

    // R8: the end flag falls only after a captured control read
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_flag) |-> $past(rd_pend && pend_sel == SW'(OFS_CTRL)));

endmodule

bind dmaseq_chan dmaseq_chan_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_vma  (bus_vma),
    .bus_addr (bus_addr),
    .dev_ack  (dev_ack),
    .dev_end  (dev_end),
    .busy     (busy),
    .end_flag (end_flag),
    .c_blk    (c_blk),
    .c_sty    (c_sty),
    .c_dec    (c_dec),
    .rd_pend  (rd_pend),
    .pend_sel (pend_sel)
);

// File: tb/dmaseq_chan_tb_top.sv
`timescale 1ns/1ps
// Bench for the DMA channel sequencer: table of transfers walked by one loop,
// then directed tests for reset, ignored writes, grant stalls and flag priority.
module dmaseq_chan_tb_top;

    localparam logic [2:0] S_AHI = 3'd0, S_ALO = 3'd1, S_CHI = 3'd2,
                           S_CLO = 3'd3, S_CTL = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rw = 1'b1;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        dev_req = 1'b0;
    logic        dev_stb, dev_ack, dev_end, bus_req, bus_gnt, bus_vma, bus_rw;
    logic [15:0] bus_addr;
    logic        busy, end_flag;

    logic gnt_echo = 1'b1, gnt_force = 1'b0, gnt_q = 1'b0;

    int chk_n = 0, fail_n = 0;

    // Monitor state
    logic        mon_on = 1'b0;
    logic [15:0] exp_addr;
    logic        exp_dec, exp_rw;
    int          nbytes, nend, gaps;
    logic        prev_end = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) gnt_q <= bus_req;
    assign bus_gnt = gnt_force | (gnt_echo & gnt_q);

    dmaseq_chan dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .dev_req(dev_req), .dev_stb(dev_stb),
        .dev_ack(dev_ack), .dev_end(dev_end), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_vma(bus_vma), .bus_rw(bus_rw),
        .bus_addr(bus_addr), .busy(busy), .end_flag(end_flag)
    );

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        chk_n++;
        if (act !== exp) begin
            fail_n++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endfunction

    // ctrl, start address, count, final address
    localparam int NV = 5;
    localparam logic [55:0] VEC [NV] = '{
        {8'h02, 16'h1000, 16'd3, 16'h1003},
        {8'h0B, 16'h0001, 16'd3, 16'hFFFE},
        {8'h05, 16'hFFFE, 16'd3, 16'h0001},
        {8'h00, 16'h2000, 16'd2, 16'h2002},
        {8'h08, 16'h0000, 16'd1, 16'hFFFF}
    };

    // Bus cycle monitor: address, direction, strobe and request gaps
    always @(negedge clk) begin
        if (mon_on) begin
            if (bus_vma) begin
                nbytes++;
                chk("R5 bus address", bus_addr, exp_addr);
                chk("R3 bus direction", bus_rw, exp_rw);
                chk("R12 strobe in bus cycle", dev_stb, 1);
                exp_addr = exp_dec ? exp_addr - 1'b1 : exp_addr + 1'b1;
            end
            if (dev_end) begin
                nend++;
                if (prev_end) chk("R7 end pulse width", 2, 1);
            end
            if (nbytes > 0 && nend == 0 && !bus_req) gaps++;
        end
        prev_end = dev_end;
    end

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(posedge clk); #1;
        cs = 1'b1; rw = 1'b0; reg_sel = s; wdata = d;
        @(posedge clk); #1;
        cs = 1'b0; rw = 1'b1;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(posedge clk); #1;
        cs = 1'b1; rw = 1'b1; reg_sel = s;
        #1 d = rdata;
        @(posedge clk); #1;
        cs = 1'b0;
    endtask

    task automatic load(input logic [7:0] c, input logic [15:0] a, input logic [15:0] n);
        wr(S_CTL, c);
        wr(S_AHI, a[15:8]);
        wr(S_ALO, a[7:0]);
        wr(S_CHI, n[15:8]);
        wr(S_CLO, n[7:0]);
    endtask

    task automatic wait_sig(input int which, input string tag);
        int k = 0;
        while (k < 200) begin
            @(negedge clk);
            if ((which == 0 && dev_ack) || (which == 1 && dev_end)) break;
            k++;
        end
        if (k >= 200) chk(tag, 0, 1);
    endtask

    task automatic one_request();
        @(posedge clk); #1 dev_req = 1'b1;
        wait_sig(0, "R11 acknowledge seen");
        @(posedge clk); #1 dev_req = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk_n++; fail_n++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
        $finish;
    end

    initial begin
        logic [7:0] d, d2;

        // R1: reset state
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 end flag", end_flag, 0);
        rd(S_AHI, d); chk("R1 addr hi", d, 0);
        rd(S_ALO, d); chk("R1 addr lo", d, 0);
        rd(S_CHI, d); chk("R1 count hi", d, 0);
        rd(S_CLO, d); chk("R1 count lo", d, 0);
        rd(S_CTL, d); chk("R1 control", d, 0);

        // R2: upper control bits are not stored
        wr(S_CTL, 8'hF5);
        rd(S_CTL, d); chk("R2 control upper bits dropped", d, 8'h05);

        // Table of transfers
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  c;
            logic [15:0] a, n, f;
            {c, a, n, f} = VEC[v];
            load(c, a, n);
            exp_addr = a; exp_dec = c[3]; exp_rw = c[0];
            nbytes = 0; nend = 0; gaps = 0;
            mon_on = 1'b1;
            if (c[1]) begin
                @(posedge clk); #1 dev_req = 1'b1;
                @(posedge clk); #1 dev_req = 1'b0;
                wait_sig(1, "R11 block end seen");
            end else begin
                for (int b = 0; b < int'(n); b++) one_request();
            end
            repeat (2) @(negedge clk);
            mon_on = 1'b0;
            chk("R11 bytes per transfer", nbytes, n);
            chk("R7 one end pulse", nend, 1);
            if (c[2]) chk("R9 request held", gaps, 0);
            else if (n > 1) chk("R10 request released", gaps > 0, 1);
            chk("R7 bus_req low after end", bus_req, 0);
            chk("R13 busy low after end", busy, 0);
            chk("R7 end flag set", end_flag, 1);
            rd(S_CTL, d);
            chk("R8 control read shows end", d, {1'b1, 3'b000, c[3:0]});
            @(negedge clk);
            chk("R8 end flag cleared by read", end_flag, 0);
            rd(S_AHI, d); rd(S_ALO, d2);
            chk("R5 final address", {d, d2}, f);
            rd(S_CHI, d); rd(S_CLO, d2);
            chk("R6 final count", {d, d2}, 0);
        end

        // R4: undefined mode code starts nothing
        load(8'h06, 16'h0100, 16'd2);
        begin
            int seen = 0;
            @(posedge clk); #1 dev_req = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (bus_req || busy) seen++;
            end
            @(posedge clk); #1 dev_req = 1'b0;
            chk("R4 undefined mode stays idle", seen, 0);
        end

        // R4: zero count starts nothing
        load(8'h02, 16'h0100, 16'd0);
        @(posedge clk); #1 dev_req = 1'b1;
        repeat (4) @(posedge clk);
        #1 dev_req = 1'b0;
        @(negedge clk);
        chk("R4 zero count stays idle", busy, 0);

        // R6: no grant, no bus cycle and no count change
        gnt_echo = 1'b0;
        load(8'h02, 16'h4000, 16'd2);
        @(posedge clk); #1 dev_req = 1'b1;
        @(posedge clk); #1 dev_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 request without grant", bus_req, 1);
        chk("R6 no bus cycle without grant", bus_vma, 0);
        chk("R13 busy while waiting", busy, 1);
        rd(S_CLO, d); chk("R6 count holds without grant", d, 2);
        gnt_echo = 1'b1;
        wait_sig(1, "R6 transfer resumes");
        rd(S_CLO, d); chk("R6 count done after grant", d, 0);
        rd(S_CTL, d);

        // R2/R13: writes to address and count ignored while held busy
        load(8'h04, 16'h3000, 16'd2);
        one_request();
        @(negedge clk);
        chk("R13 busy between held bytes", busy, 1);
        wr(S_ALO, 8'h55);
        wr(S_CLO, 8'h09);
        @(negedge clk);
        chk("R9 request held between bytes", bus_req, 1);
        rd(S_CTL, d); chk("R13 busy bit in control", d[6], 1);
        @(posedge clk); #1 dev_req = 1'b1;
        wait_sig(0, "R11 second acknowledge");
        chk("R7 end with last acknowledge", dev_end, 1);
        @(posedge clk); #1 dev_req = 1'b0;
        rd(S_ALO, d); chk("R2 address write ignored while busy", d, 8'h02);
        rd(S_CLO, d); chk("R2 count write ignored while busy", d, 8'h00);
        rd(S_CTL, d);

        // R8: end set and control read on the same edge, set wins
        gnt_force = 1'b1;
        load(8'h00, 16'h5000, 16'd1);
        @(posedge clk); #1 dev_req = 1'b1;
        @(posedge clk); #1 dev_req = 1'b0;
        @(posedge clk); #1 cs = 1'b1; rw = 1'b1; reg_sel = S_CTL;
        chk("R8 final bus cycle aligned with read", bus_vma, 1);
        @(posedge clk); #1 cs = 1'b0;
        chk("R8 set wins over same-edge clear", end_flag, 1);
        chk("R7 end pulse after final cycle", dev_end, 1);
        rd(S_CTL, d); chk("R8 flag visible to later read", d[7], 1);
        @(negedge clk);
        chk("R8 flag cleared by later read", end_flag, 0);
        gnt_force = 1'b0;

        $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
        $finish;
    end

endmodule